// File: doc/BRIEF.md
# Interrupt Status and Mask Bank

This block gathers the interrupt sources of a monitoring peripheral into one memory-mapped bank and drives a single level-sensitive interrupt line. Each hardware source arrives as a single-cycle pulse that sets a sticky status bit. Software clears status bits by writing ones. The bank also holds a per-bit mask that suppresses status bits from the interrupt line.

Software cannot write the mask directly. It changes the mask through two command words: one unmasks the bits written as one, and the other masks them. A third command word sets status bits by hand. Because every command acts only on the bits written as one, software never needs a read-modify-write sequence.

Any access to an offset outside the five mapped words is recorded in the status bank as an address fault.

The bus is a plain request/write-enable/address/data port with 32-bit words only. Read data appears on the cycle after the request.

Top module: `irq_bank`

## Requirements
- R1: After reset the status word is 0x00000000, the mask word is 0x81FFFFFF, `irq_o` is low and `bus_rdata` is zero.
- R2: `irq_o` is high exactly when some status bit is set whose mask bit is clear. It follows every status or mask change in the same cycle that the changed register is visible.
- R3: A read request places data on `bus_rdata` one cycle later. Offset 0x04 returns the status word and 0x08 returns the mask word. The command offsets 0x0C, 0x10 and 0x14 always return zero.
- R4: A write to offset 0x04 clears each status bit among bits 31 and 23:0 where the written data is one, and leaves the other bits unchanged.
- R5: A write to the mask offset 0x08 changes nothing.
- R6: A write to 0x0C clears the mask bits (31, 23:0) where the data is one. A write to 0x10 sets those mask bits where the data is one.
- R7: A write to 0x14 sets the status bits (31, 23:0) where the data is one.
- R8: A pulse on `evt_i[k]` sets status bit k at the next clock edge. Bits 9:0 are the first alarm group, bit 10 is its over-temperature, bit 11 is the monitor over-temperature, bits 12 and 13 are end-of-conversion for converters 0 and 1, bits 14 and 15 are end-of-sequence for those converters, bits 22:16 are the second alarm group, and bit 23 is its over-temperature.
- R9: If a source pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: A request to any other offset, including one with address bits 1:0 not zero, sets status bit 31 and reads as zero. It changes no other state.
- R11: Status bits 30:24 always read zero. Data bits 30:24 written to 0x0C, 0x10 or 0x14 are ignored, so mask bit 24 stays one and mask bits 30:25 stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | SRC_W (24) | Single-cycle source event pulses, bit k sets status bit k |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Level interrupt request |

## Verification
A status or mask bit stuck in the wrong value appears at `irq_o` in the cycle after the offending edge, provided the bit's partner is in the state that lets it through. It also appears on `bus_rdata` one cycle after the next read of that word. The stimulus therefore walks each bit pattern with its mask both open and closed, so that both paths expose the error. A mis-decoded offset shows up at once, either as a spurious fault bit 31 on the next status read or as a command that lands in the wrong word. The same-cycle set-versus-clear race is driven explicitly, because it is invisible under ordinary traffic.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int WORD_W = 32;
    localparam int ERR_BIT = 31;

    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_MASK = 8'h08;
    localparam logic [7:0] OFF_EN   = 8'h0C;
    localparam logic [7:0] OFF_DIS  = 8'h10;
    localparam logic [7:0] OFF_TRIG = 8'h14;

    typedef struct packed {
        logic stat_wr;
        logic stat_rd;
        logic mask_rd;
        logic en_wr;
        logic dis_wr;
        logic trig_wr;
        logic bad;
    } bus_cmd_t;

    function automatic logic [WORD_W-1:0] live_mask(input int src_w);
        return ((WORD_W'(1) << src_w) - WORD_W'(1)) | (WORD_W'(1) << ERR_BIT);
    endfunction

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output bus_cmd_t          cmd
);

    always_comb begin
        cmd = '0;
        if (req) begin
            case (addr)
                ADDR_W'(OFF_STAT): begin
                    cmd.stat_wr = we;
                    cmd.stat_rd = !we;
                end
                ADDR_W'(OFF_MASK): cmd.mask_rd = !we;
                ADDR_W'(OFF_EN):   cmd.en_wr   = we;
                ADDR_W'(OFF_DIS):  cmd.dis_wr  = we;
                ADDR_W'(OFF_TRIG): cmd.trig_wr = we;
                default:           cmd.bad     = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/irq_bank_status.sv
module irq_bank_status
    import irq_bank_pkg::*;
#(
    parameter int SRC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  evt_i,
    input  bus_cmd_t          cmd,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] isr_q
);

    localparam logic [WORD_W-1:0] LIVE = live_mask(SRC_W);
    localparam logic [WORD_W-1:0] ERR1 = WORD_W'(1) << ERR_BIT;

    typedef struct packed {
        logic [WORD_W-1:0] isr;
    } st_t;

    st_t st_d, st_q;
    logic [WORD_W-1:0] clr_v, set_v;

    always_comb begin
        st_d  = st_q;
        clr_v = cmd.stat_wr ? (wdata & LIVE) : '0;
        // hardware sources, software trigger and address fault all set bits;
        // applied after the clear so a colliding set wins
        set_v = WORD_W'(evt_i)
              | (cmd.trig_wr ? (wdata & LIVE) : '0)
              | (cmd.bad ? ERR1 : '0);
        st_d.isr = ((st_q.isr & ~clr_v) | set_v) & LIVE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr_q = st_q.isr;

endmodule

// File: rtl/irq_bank_mask.sv
module irq_bank_mask
    import irq_bank_pkg::*;
#(
    parameter int SRC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cmd_t          cmd,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] imr_q
);

    localparam logic [WORD_W-1:0] LIVE    = live_mask(SRC_W);
    localparam logic [WORD_W-1:0] RST_VAL = LIVE | (WORD_W'(1) << SRC_W);

    typedef struct packed {
        logic [WORD_W-1:0] imr;
    } mk_t;

    mk_t mk_d, mk_q;
    logic [WORD_W-1:0] open_v, shut_v;

    always_comb begin
        mk_d   = mk_q;
        open_v = cmd.en_wr  ? (wdata & LIVE) : '0;
        shut_v = cmd.dis_wr ? (wdata & LIVE) : '0;
        mk_d.imr = (mk_q.imr & ~open_v) | shut_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mk_q <= '{imr: RST_VAL};
        else        mk_q <= mk_d;
    end

    assign imr_q = mk_q.imr;

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  evt_i,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o
);

    bus_cmd_t          cmd;
    logic [WORD_W-1:0] isr_q, imr_q;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    irq_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req  (bus_req),
        .we   (bus_we),
        .addr (bus_addr),
        .cmd  (cmd)
    );

    irq_bank_status #(.SRC_W(SRC_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .cmd   (cmd),
        .wdata (bus_wdata),
        .isr_q (isr_q)
    );

    irq_bank_mask #(.SRC_W(SRC_W)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .wdata (bus_wdata),
        .imr_q (imr_q)
    );

    always_comb begin
        rd_d = '0;
        if (cmd.stat_rd)      rd_d.rdata = isr_q;
        else if (cmd.mask_rd) rd_d.rdata = imr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;
    assign irq_o     = |(isr_q & ~imr_q);

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SRC_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  evt_i,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic [WORD_W-1:0] isr_q,
    input logic [WORD_W-1:0] imr_q
);

    localparam logic [WORD_W-1:0] LIVE = live_mask(SRC_W);

    logic mapped, mask_cmd, zero_rd;
    assign mapped = (bus_addr == ADDR_W'(OFF_STAT)) || (bus_addr == ADDR_W'(OFF_MASK))
                 || (bus_addr == ADDR_W'(OFF_EN))   || (bus_addr == ADDR_W'(OFF_DIS))
                 || (bus_addr == ADDR_W'(OFF_TRIG));
    assign mask_cmd = bus_req && bus_we
                   && ((bus_addr == ADDR_W'(OFF_EN)) || (bus_addr == ADDR_W'(OFF_DIS)));
    assign zero_rd  = bus_req && !bus_we
                   && ((bus_addr == ADDR_W'(OFF_EN)) || (bus_addr == ADDR_W'(OFF_DIS))
                    || (bus_addr == ADDR_W'(OFF_TRIG)));

    // R8
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((isr_q[SRC_W-1:0] & $past(evt_i)) == $past(evt_i)));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_cmd |=> $stable(imr_q));

    // R7
    trig_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_W'(OFF_TRIG))
        |=> ((isr_q & $past(bus_wdata) & LIVE) == ($past(bus_wdata) & LIVE)));

    // R10
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !mapped) |=> (isr_q[ERR_BIT] && bus_rdata == '0));

    // R3
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_rd |=> (bus_rdata == '0));

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_q[30:24] == 7'd0 && imr_q[30:25] == 6'd0 && imr_q[24]);

    // R2
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(bus_req || (|evt_i)));

endmodule

bind irq_bank irq_bank_chk #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .isr_q     (isr_q),
    .imr_q     (imr_q)
);

// File: tb/irq_bank_tb.sv
`timescale 1ns/1ps
module irq_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] evt_i = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    irq_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // we, addr, wdata, expected read data, expected irq
    localparam int NV = 20;
    localparam logic [73:0] VEC [0:NV-1] = '{
        {1'b0, 8'h04, 32'h0,         32'h0000_0000, 1'b0}, // R3 status read
        {1'b0, 8'h08, 32'h0,         32'h81FF_FFFF, 1'b0}, // R3 mask read
        {1'b1, 8'h14, 32'h0000_0005, 32'h0,         1'b0}, // R7 trigger, masked
        {1'b0, 8'h04, 32'h0,         32'h0000_0005, 1'b0}, // R7
        {1'b1, 8'h0C, 32'h0000_0001, 32'h0,         1'b1}, // R6 unmask bit0
        {1'b0, 8'h08, 32'h0,         32'h81FF_FFFE, 1'b1}, // R6
        {1'b0, 8'h0C, 32'h0,         32'h0000_0000, 1'b1}, // R3 enable reads zero
        {1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,         1'b1}, // R5 mask write
        {1'b0, 8'h08, 32'h0,         32'h81FF_FFFE, 1'b1}, // R5
        {1'b1, 8'h04, 32'h0000_0001, 32'h0,         1'b0}, // R4 clear bit0
        {1'b0, 8'h04, 32'h0,         32'h0000_0004, 1'b0}, // R4
        {1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0,         1'b1}, // R6 R11 unmask all
        {1'b0, 8'h08, 32'h0,         32'h0100_0000, 1'b1}, // R11 bit24 stays
        {1'b1, 8'h10, 32'h0000_0004, 32'h0,         1'b0}, // R6 mask bit2
        {1'b0, 8'h10, 32'h0,         32'h0000_0000, 1'b0}, // R3 disable reads zero
        {1'b1, 8'h14, 32'h7F00_0000, 32'h0,         1'b0}, // R11 reserved trigger
        {1'b0, 8'h04, 32'h0,         32'h0000_0004, 1'b0}, // R11
        {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0,         1'b0}, // R4 clear all
        {1'b0, 8'h14, 32'h0,         32'h0000_0000, 1'b0}, // R3 trigger reads zero
        {1'b0, 8'h04, 32'h0,         32'h0000_0000, 1'b0}  // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, return at the next falling edge
    task automatic cycle(input logic req, input logic we, input logic [7:0] addr,
                         input logic [31:0] data, input logic [23:0] ev);
        bus_req   = req;
        bus_we    = we;
        bus_addr  = addr;
        bus_wdata = data;
        evt_i     = ev;
        @(posedge clk);
        @(negedge clk);
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        evt_i     = '0;
    endtask

    task automatic rd(input logic [7:0] addr, input string req, input logic [31:0] exp);
        cycle(1'b1, 1'b0, addr, 32'h0, 24'h0);
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'd0, irq_o}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cycle(1'b1, VEC[i][73], VEC[i][72:65], VEC[i][64:33], 24'h0);
            if (!VEC[i][73]) check("R3 table read", bus_rdata, VEC[i][32:1]);
            check("R2 table irq", {31'd0, irq_o}, {31'd0, VEC[i][0]});
        end

        // mask now 0x01000004, status clear
        cycle(1'b0, 1'b0, 8'h0, 32'h0, 24'h00_0400);
        check("R8 irq bit10", {31'd0, irq_o}, 32'd1);
        rd(8'h04, "R8 bit10", 32'h0000_0400);
        cycle(1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF, 24'h0);
        check("R4 irq cleared", {31'd0, irq_o}, 32'd0);
        cycle(1'b0, 1'b0, 8'h0, 32'h0, 24'h00_0004);
        check("R2 masked event", {31'd0, irq_o}, 32'd0);
        rd(8'h04, "R8 bit2", 32'h0000_0004);
        cycle(1'b0, 1'b0, 8'h0, 32'h0, 24'h80_0000);
        check("R8 irq bit23", {31'd0, irq_o}, 32'd1);
        rd(8'h04, "R8 bit23", 32'h0080_0004);

        // R9 set wins over same-cycle clear
        cycle(1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF, 24'h0);
        cycle(1'b1, 1'b1, 8'h04, 32'h0000_0020, 24'h00_0020);
        rd(8'h04, "R9 collision", 32'h0000_0020);

        // R10 unmapped offsets
        rd(8'h20, "R10 read zero", 32'h0);
        check("R10 irq fault", {31'd0, irq_o}, 32'd1);
        rd(8'h04, "R10 fault bit", 32'h8000_0020);
        cycle(1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF, 24'h0);
        cycle(1'b1, 1'b1, 8'h05, 32'hFFFF_FFFF, 24'h0);
        rd(8'h04, "R10 misaligned", 32'h8000_0000);
        rd(8'h08, "R10 mask untouched", 32'h0100_0004);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(8'h04, "R1 status", 32'h0);
        rd(8'h08, "R1 mask", 32'h81FF_FFFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule